// File: doc/BRIEF.md
# Miss Entry Target List Manager

This block tracks one outstanding cache-line miss together with every requester waiting on it. Each waiting requester is kept as a compact descriptor: a request kind, a source (processor, snoop or prefetcher), an allocate-on-fill bit, a pending mark and an ordering tag. Descriptors sit in one of two bounded queues. The active queue holds requesters that the outstanding request will satisfy. The deferred queue holds requesters that must wait for a fresh request once the current one completes.

A controller drives one command per cycle: claim the entry with a first requester, attach a further requester, mark the request as issued downstream, retire the oldest active requester, or release the entry. For each attached requester the block picks the queue. The choice depends on cache-maintenance kinds, on whether deferred work already exists, and on the issued / pending-invalidate / pending-downgrade / writability state. When a requester is deferred behind an invalidation, upgrade-style kinds are rewritten to the kind that will fetch a fresh copy. Summary flags over the active queue tell the controller whether a writable copy is needed, whether an upgrade is present and whether the line should be allocated on fill.

Top module: `miss_target_mgr`

## Requirements
- R1: A claim (op 0) on an idle entry makes it busy with exactly one active requester, marked pending, with issued, pending-modified, pending-invalidate and pending-downgrade all 0. That requester's source is prefetcher (2) when its kind is prefetch (5), otherwise processor (0). The forward bit is loaded from the claim-time input.
- R2: An attached requester (op 1) goes to the deferred queue if its own kind is maintenance (6), or the oldest active requester is maintenance, or the deferred queue is not empty.
- R3: It is also deferred when the entry is issued and either a pending invalidate is recorded, or the requester needs a writable copy (kinds 1, 2, 3, 4, 7, 8) while pending-modified is 0, a pending downgrade is recorded, or the forward bit is set; otherwise it joins the active queue. Pending invalidate and downgrade are recorded from their set inputs only while the entry is busy and issued.
- R4: A requester deferred while issued with a pending invalidate is stored rewritten: upgrade (2) becomes read-exclusive (1), conditional-store upgrade (3) becomes its fail kind (7), conditional store (4) becomes its fail kind (8); other kinds are kept.
- R5: The needs-writable, has-upgrade (kinds 2, 3, 4) and allocate-on-fill outputs are each the OR over the active requesters whose source is not snoop (1); snoop requesters never raise them.
- R6: Marking issued (op 2) on a busy, not yet issued entry sets issued, loads pending-modified with needs-writable OR the external pending-modified input, and clears pending invalidate and pending downgrade.
- R7: A requester that joins the active queue while the entry is not issued is marked pending; one that joins after issue is not.
- R8: An attach whose chosen queue is full raises stall in that cycle, and no queue or state changes.
- R9: Err rises in the cycle of a claim on a busy entry, an attach of a prefetch kind, an attach on an idle entry, a mark-issued on an idle or already issued entry, or a retire with an empty active queue; the command then has no effect.
- R10: Release (op 4) is accepted only with an empty active queue. It empties the deferred queue and clears busy, issued and all flags; with active requesters present it raises err and is ignored.
- R11: Retire (op 3) removes the oldest active requester, so active requesters leave in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | A command is present this cycle |
| op_code | input | 3 | 0 claim, 1 attach, 2 mark issued, 3 retire, 4 release; 5 to 7 do nothing |
| tgt_kind | input | 4 | Requester kind for claim or attach |
| tgt_src | input | 2 | Requester source for attach: 0 processor, 1 snoop, 2 prefetcher |
| tgt_fill | input | 1 | Allocate-on-fill wish of the requester |
| tgt_order | input | 8 | Ordering tag of the requester |
| svc_pend_mod | input | 1 | External pending-modified hint used at mark issued |
| snp_inv_set | input | 1 | Record a pending invalidate |
| snp_dwn_set | input | 1 | Record a pending downgrade |
| alloc_fwd | input | 1 | Forward bit loaded at claim |
| busy | output | 1 | Entry holds a miss |
| in_service | output | 1 | Request has been issued downstream |
| pend_mod | output | 1 | A modified response is expected |
| post_inval | output | 1 | Pending invalidate recorded |
| post_down | output | 1 | Pending downgrade recorded |
| need_wr | output | 1 | Active summary: writable copy needed |
| has_upgrade | output | 1 | Active summary: upgrade present |
| fill_alloc | output | 1 | Active summary: allocate on fill |
| act_count | output | 3 | Number of active requesters |
| def_count | output | 3 | Number of deferred requesters |
| act_head_kind | output | 4 | Kind of the oldest active requester (0 when empty) |
| act_head_src | output | 2 | Source of the oldest active requester |
| act_head_order | output | 8 | Tag of the oldest active requester |
| act_head_pend | output | 1 | Pending mark of the oldest active requester |
| def_head_kind | output | 4 | Stored kind of the oldest deferred requester |
| def_head_order | output | 8 | Tag of the oldest deferred requester |
| stall | output | 1 | Attach refused this cycle because the chosen queue is full |
| err | output | 1 | Illegal command this cycle |

## Verification
A wrong queue decision shows as a count of the wrong queue moving one clock after the attach. It also shows later, when retires bring the misplaced requester to the active head in the wrong position, or when the deferred head carries an unrewritten kind. Stale or sticky summary flags show at the next mark-issued, which copies needs-writable into pending-modified. That in turn changes where the following writable requester lands, so one bad bit spreads into queue placement within a few commands. Stall and err are combinational and show in the cycle of the command.

// File: rtl/mte_pkg.sv
package mte_pkg;
  localparam int unsigned ORDER_W = 8;
  localparam int unsigned KIND_W  = 4;
  localparam int unsigned SRC_W   = 2;
  localparam int unsigned OP_W    = 3;

  localparam logic [KIND_W-1:0] K_READ        = 4'd0;
  localparam logic [KIND_W-1:0] K_READ_EX     = 4'd1;
  localparam logic [KIND_W-1:0] K_UPGRADE     = 4'd2;
  localparam logic [KIND_W-1:0] K_SC_UPG      = 4'd3;
  localparam logic [KIND_W-1:0] K_STORE_COND  = 4'd4;
  localparam logic [KIND_W-1:0] K_PREFETCH    = 4'd5;
  localparam logic [KIND_W-1:0] K_MAINT       = 4'd6;
  localparam logic [KIND_W-1:0] K_SC_UPG_FAIL = 4'd7;
  localparam logic [KIND_W-1:0] K_SC_FAIL     = 4'd8;

  localparam logic [SRC_W-1:0] S_CPU   = 2'd0;
  localparam logic [SRC_W-1:0] S_SNOOP = 2'd1;
  localparam logic [SRC_W-1:0] S_PF    = 2'd2;

  localparam logic [OP_W-1:0] OP_ALLOC   = 3'd0;
  localparam logic [OP_W-1:0] OP_ADD     = 3'd1;
  localparam logic [OP_W-1:0] OP_SERVICE = 3'd2;
  localparam logic [OP_W-1:0] OP_RETIRE  = 3'd3;
  localparam logic [OP_W-1:0] OP_DEALLOC = 3'd4;

  typedef struct packed {
    logic [KIND_W-1:0]  kind;
    logic [SRC_W-1:0]   src;
    logic               fill;
    logic               pend;
    logic [ORDER_W-1:0] order;
  } tgt_t;

  function automatic logic kind_needs_wr(input logic [KIND_W-1:0] k);
    return (k == K_READ_EX) || (k == K_UPGRADE) || (k == K_SC_UPG) ||
           (k == K_STORE_COND) || (k == K_SC_UPG_FAIL) || (k == K_SC_FAIL);
  endfunction

  function automatic logic kind_is_upg(input logic [KIND_W-1:0] k);
    return (k == K_UPGRADE) || (k == K_SC_UPG) || (k == K_STORE_COND);
  endfunction

  function automatic logic kind_is_maint(input logic [KIND_W-1:0] k);
    return k == K_MAINT;
  endfunction

  function automatic logic [KIND_W-1:0] kind_fail(input logic [KIND_W-1:0] k);
    logic [KIND_W-1:0] r;
    case (k)
      K_UPGRADE:    r = K_READ_EX;
      K_SC_UPG:     r = K_SC_UPG_FAIL;
      K_STORE_COND: r = K_SC_FAIL;
      default:      r = k;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/mte_fifo.sv
module mte_fifo
  import mte_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                push,
  input  tgt_t                push_d,
  input  logic                pop,
  input  logic                clr,
  output logic [CW-1:0]       count,
  output logic                full,
  output tgt_t                head,
  output tgt_t [DEPTH-1:0]    slots,
  output logic [DEPTH-1:0]    slot_vld
);
  tgt_t [DEPTH-1:0] mem_q;
  logic [PW-1:0]    rd_q, rd_d, wr_q, wr_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             do_push, do_pop;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign do_push = push && (cnt_q != CW'(DEPTH)) && !clr;
  assign do_pop  = pop && (cnt_q != '0) && !clr;

  always_comb begin
    rd_d  = rd_q;
    wr_d  = wr_q;
    cnt_d = cnt_q;
    if (clr) begin
      rd_d  = '0;
      wr_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wr_d = ptr_inc(wr_q);
      if (do_pop)  rd_d = ptr_inc(rd_q);
      if (do_push && !do_pop)      cnt_d = cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wr_q] <= push_d;
  end

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_vld
      always_comb begin
        int unsigned off;
        off = (gi + DEPTH - int'(rd_q)) % DEPTH;
        slot_vld[gi] = off < int'(cnt_q);
      end
    end
  endgenerate

  assign slots = mem_q;
  assign count = cnt_q;
  assign full  = (cnt_q == CW'(DEPTH));
  assign head  = (cnt_q != '0) ? mem_q[rd_q] : '0;
endmodule

// File: rtl/mte_summary.sv
module mte_summary
  import mte_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  tgt_t [DEPTH-1:0] slots,
  input  logic [DEPTH-1:0] slot_vld,
  output logic             need_wr,
  output logic             has_upg,
  output logic             fill
);
  logic [DEPTH-1:0] c_wr, c_upg, c_fill;

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_slot
      logic use_it;
      assign use_it     = slot_vld[gi] && (slots[gi].src != S_SNOOP);
      assign c_wr[gi]   = use_it && kind_needs_wr(slots[gi].kind);
      assign c_upg[gi]  = use_it && kind_is_upg(slots[gi].kind);
      assign c_fill[gi] = use_it && slots[gi].fill;
    end
  endgenerate

  assign need_wr = |c_wr;
  assign has_upg = |c_upg;
  assign fill    = |c_fill;
endmodule

// File: rtl/mte_route.sv
module mte_route
  import mte_pkg::*;
(
  input  logic [KIND_W-1:0] kind,
  input  logic              in_svc,
  input  logic              post_inval,
  input  logic              post_down,
  input  logic              pend_mod,
  input  logic              fwd,
  input  logic              act_empty,
  input  logic [KIND_W-1:0] act_head_kind,
  input  logic              def_empty,
  output logic              to_def,
  output logic [KIND_W-1:0] kind_out
);
  logic maint_hit, svc_hit, wr_blocked;

  assign maint_hit  = kind_is_maint(kind) ||
                      (!act_empty && kind_is_maint(act_head_kind)) ||
                      !def_empty;
  assign wr_blocked = kind_needs_wr(kind) && (!pend_mod || post_down || fwd);
  assign svc_hit    = in_svc && (post_inval || wr_blocked);
  assign to_def     = maint_hit || svc_hit;
  assign kind_out   = (to_def && in_svc && post_inval) ? kind_fail(kind) : kind;
endmodule

// File: rtl/miss_target_mgr.sv
module miss_target_mgr
  import mte_pkg::*;
#(
  parameter int unsigned ACT_DEPTH = 4,
  parameter int unsigned DEF_DEPTH = 4,
  localparam int unsigned ACW = $clog2(ACT_DEPTH + 1),
  localparam int unsigned DCW = $clog2(DEF_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               op_valid,
  input  logic [OP_W-1:0]    op_code,
  input  logic [KIND_W-1:0]  tgt_kind,
  input  logic [SRC_W-1:0]   tgt_src,
  input  logic               tgt_fill,
  input  logic [ORDER_W-1:0] tgt_order,
  input  logic               svc_pend_mod,
  input  logic               snp_inv_set,
  input  logic               snp_dwn_set,
  input  logic               alloc_fwd,
  output logic               busy,
  output logic               in_service,
  output logic               pend_mod,
  output logic               post_inval,
  output logic               post_down,
  output logic               need_wr,
  output logic               has_upgrade,
  output logic               fill_alloc,
  output logic [ACW-1:0]     act_count,
  output logic [DCW-1:0]     def_count,
  output logic [KIND_W-1:0]  act_head_kind,
  output logic [SRC_W-1:0]   act_head_src,
  output logic [ORDER_W-1:0] act_head_order,
  output logic               act_head_pend,
  output logic [KIND_W-1:0]  def_head_kind,
  output logic [ORDER_W-1:0] def_head_order,
  output logic               stall,
  output logic               err
);
  logic busy_q, busy_d, svc_q, svc_d, pmod_q, pmod_d;
  logic pinv_q, pinv_d, pdwn_q, pdwn_d, fwd_q, fwd_d;

  logic is_alloc, is_add, is_svc, is_ret, is_dealloc;
  logic alloc_ok, add_legal, add_ok, svc_ok, ret_ok, dealloc_ok;
  logic to_def, dest_full;
  logic [KIND_W-1:0] routed_kind;

  logic act_push, act_pop, def_push, def_clr;
  tgt_t act_push_d, def_push_d;
  logic act_full, def_full;
  tgt_t act_head, def_head;
  tgt_t [ACT_DEPTH-1:0] act_slots;
  logic [ACT_DEPTH-1:0] act_vld;
  tgt_t [DEF_DEPTH-1:0] def_slots_unused;
  logic [DEF_DEPTH-1:0] def_vld_unused;
  logic act_empty, def_empty;

  assign act_empty = (act_count == '0);
  assign def_empty = (def_count == '0);

  // command decode
  assign is_alloc   = op_valid && (op_code == OP_ALLOC);
  assign is_add     = op_valid && (op_code == OP_ADD);
  assign is_svc     = op_valid && (op_code == OP_SERVICE);
  assign is_ret     = op_valid && (op_code == OP_RETIRE);
  assign is_dealloc = op_valid && (op_code == OP_DEALLOC);

  mte_route u_route (
    .kind          (tgt_kind),
    .in_svc        (svc_q),
    .post_inval    (pinv_q),
    .post_down     (pdwn_q),
    .pend_mod      (pmod_q),
    .fwd           (fwd_q),
    .act_empty     (act_empty),
    .act_head_kind (act_head.kind),
    .def_empty     (def_empty),
    .to_def        (to_def),
    .kind_out      (routed_kind)
  );

  assign dest_full  = to_def ? def_full : act_full;
  assign alloc_ok   = is_alloc && !busy_q;
  assign add_legal  = is_add && busy_q && (tgt_kind != K_PREFETCH);
  assign add_ok     = add_legal && !dest_full;
  assign svc_ok     = is_svc && busy_q && !svc_q;
  assign ret_ok     = is_ret && !act_empty;
  assign dealloc_ok = is_dealloc && busy_q && act_empty;

  assign stall = add_legal && dest_full;
  assign err   = (is_alloc && busy_q) ||
                 (is_add && (!busy_q || (tgt_kind == K_PREFETCH))) ||
                 (is_svc && (!busy_q || svc_q)) ||
                 (is_ret && act_empty) ||
                 (is_dealloc && (!busy_q || !act_empty));

  // queue controls
  always_comb begin
    act_push   = 1'b0;
    def_push   = 1'b0;
    act_push_d = '0;
    def_push_d = '0;
    if (alloc_ok) begin
      act_push         = 1'b1;
      act_push_d.kind  = tgt_kind;
      act_push_d.src   = (tgt_kind == K_PREFETCH) ? S_PF : S_CPU;
      act_push_d.fill  = tgt_fill;
      act_push_d.pend  = 1'b1;
      act_push_d.order = tgt_order;
    end else if (add_ok) begin
      if (to_def) begin
        def_push         = 1'b1;
        def_push_d.kind  = routed_kind;
        def_push_d.src   = tgt_src;
        def_push_d.fill  = tgt_fill;
        def_push_d.pend  = 1'b0;
        def_push_d.order = tgt_order;
      end else begin
        act_push         = 1'b1;
        act_push_d.kind  = tgt_kind;
        act_push_d.src   = tgt_src;
        act_push_d.fill  = tgt_fill;
        act_push_d.pend  = !svc_q;
        act_push_d.order = tgt_order;
      end
    end
  end

  assign act_pop = ret_ok;
  assign def_clr = dealloc_ok;

  mte_fifo #(.DEPTH(ACT_DEPTH)) u_act (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (act_push),
    .push_d   (act_push_d),
    .pop      (act_pop),
    .clr      (1'b0),
    .count    (act_count),
    .full     (act_full),
    .head     (act_head),
    .slots    (act_slots),
    .slot_vld (act_vld)
  );

  mte_fifo #(.DEPTH(DEF_DEPTH)) u_def (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (def_push),
    .push_d   (def_push_d),
    .pop      (1'b0),
    .clr      (def_clr),
    .count    (def_count),
    .full     (def_full),
    .head     (def_head),
    .slots    (def_slots_unused),
    .slot_vld (def_vld_unused)
  );

  mte_summary #(.DEPTH(ACT_DEPTH)) u_sum (
    .slots    (act_slots),
    .slot_vld (act_vld),
    .need_wr  (need_wr),
    .has_upg  (has_upgrade),
    .fill     (fill_alloc)
  );

  // entry state, next-state
  always_comb begin
    busy_d = busy_q;
    svc_d  = svc_q;
    pmod_d = pmod_q;
    pinv_d = pinv_q;
    pdwn_d = pdwn_q;
    fwd_d  = fwd_q;
    if (alloc_ok) begin
      busy_d = 1'b1;
      svc_d  = 1'b0;
      pmod_d = 1'b0;
      pinv_d = 1'b0;
      pdwn_d = 1'b0;
      fwd_d  = alloc_fwd;
    end else if (dealloc_ok) begin
      busy_d = 1'b0;
      svc_d  = 1'b0;
      pmod_d = 1'b0;
      pinv_d = 1'b0;
      pdwn_d = 1'b0;
      fwd_d  = 1'b0;
    end else if (svc_ok) begin
      svc_d  = 1'b1;
      pmod_d = need_wr || svc_pend_mod;
      pinv_d = 1'b0;
      pdwn_d = 1'b0;
    end else if (busy_q && svc_q) begin
      pinv_d = pinv_q || snp_inv_set;
      pdwn_d = pdwn_q || snp_dwn_set;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      svc_q  <= 1'b0;
      pmod_q <= 1'b0;
      pinv_q <= 1'b0;
      pdwn_q <= 1'b0;
      fwd_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      svc_q  <= svc_d;
      pmod_q <= pmod_d;
      pinv_q <= pinv_d;
      pdwn_q <= pdwn_d;
      fwd_q  <= fwd_d;
    end
  end

  assign busy           = busy_q;
  assign in_service     = svc_q;
  assign pend_mod       = pmod_q;
  assign post_inval     = pinv_q;
  assign post_down      = pdwn_q;
  assign act_head_kind  = act_head.kind;
  assign act_head_src   = act_head.src;
  assign act_head_order = act_head.order;
  assign act_head_pend  = act_head.pend;
  assign def_head_kind  = def_head.kind;
  assign def_head_order = def_head.order;
endmodule

// File: rtl/miss_target_mgr_chk.sv
module miss_target_mgr_chk
  import mte_pkg::*;
#(
  parameter int unsigned ACT_DEPTH = 4,
  parameter int unsigned DEF_DEPTH = 4,
  localparam int unsigned ACW = $clog2(ACT_DEPTH + 1),
  localparam int unsigned DCW = $clog2(DEF_DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic [OP_W-1:0]   op_code,
  input logic              svc_pend_mod,
  input logic              busy,
  input logic              in_service,
  input logic              pend_mod,
  input logic              post_inval,
  input logic              post_down,
  input logic              need_wr,
  input logic              has_upgrade,
  input logic              fill_alloc,
  input logic [ACW-1:0]    act_count,
  input logic [DCW-1:0]    def_count,
  input logic              act_head_pend,
  input logic              stall,
  input logic              err
);
  a_r1_claim_state: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_ALLOC && !busy) |=>
      (busy && act_count == ACW'(1) && !in_service && act_head_pend));

  a_r2_deferred_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_ADD && !err && !stall && def_count != '0) |=>
      (def_count == $past(def_count) + DCW'(1)));

  a_r5_idle_flags_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!need_wr && !has_upgrade && !fill_alloc && act_count == '0));

  a_r6_issue_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_SERVICE && busy && !in_service) |=>
      (in_service && !post_inval && !post_down &&
       pend_mod == $past(need_wr || svc_pend_mod)));

  a_r8_stall_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(act_count) && $stable(def_count)));

  a_r9_claim_busy_err: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_ALLOC && busy) |-> err);

  a_r10_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_DEALLOC && busy && act_count == '0) |=>
      (!busy && !in_service && def_count == '0 && !pend_mod));

  a_r11_count_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    (act_count <= ACW'(ACT_DEPTH) && def_count <= DCW'(DEF_DEPTH)));
endmodule

bind miss_target_mgr miss_target_mgr_chk #(
  .ACT_DEPTH(ACT_DEPTH),
  .DEF_DEPTH(DEF_DEPTH)
) u_chk (.*);

// File: tb/test_miss_target_mgr.sv
module test_miss_target_mgr;
  import mte_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 4;

  logic clk, rst_n;
  logic op_valid;
  logic [2:0] op_code;
  logic [3:0] tgt_kind;
  logic [1:0] tgt_src;
  logic tgt_fill;
  logic [7:0] tgt_order;
  logic svc_pend_mod, snp_inv_set, snp_dwn_set, alloc_fwd;
  logic busy, in_service, pend_mod, post_inval, post_down;
  logic need_wr, has_upgrade, fill_alloc;
  logic [2:0] act_count, def_count;
  logic [3:0] act_head_kind, def_head_kind;
  logic [1:0] act_head_src;
  logic [7:0] act_head_order, def_head_order;
  logic act_head_pend, stall, err;

  miss_target_mgr i_miss_target_mgr (.*);

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model state
  int m_busy, m_svc, m_pmod, m_pinv, m_pdwn, m_fwd;
  int a_n, d_n;
  int a_kind[DEPTH], a_src[DEPTH], a_fill[DEPTH], a_pend[DEPTH], a_ord[DEPTH];
  int d_kind[DEPTH], d_ord[DEPTH];

  function automatic int f_wr(int k);
    return (k == 1 || k == 2 || k == 3 || k == 4 || k == 7 || k == 8) ? 1 : 0;
  endfunction
  function automatic int f_upg(int k);
    return (k == 2 || k == 3 || k == 4) ? 1 : 0;
  endfunction
  function automatic int f_failk(int k);
    if (k == 2) return 1;
    if (k == 3) return 7;
    if (k == 4) return 8;
    return k;
  endfunction

  function automatic int sum_wr();
    int r = 0;
    for (int i = 0; i < a_n; i++) if (a_src[i] != 1 && f_wr(a_kind[i]) == 1) r = 1;
    return r;
  endfunction
  function automatic int sum_upg();
    int r = 0;
    for (int i = 0; i < a_n; i++) if (a_src[i] != 1 && f_upg(a_kind[i]) == 1) r = 1;
    return r;
  endfunction
  function automatic int sum_fill();
    int r = 0;
    for (int i = 0; i < a_n; i++) if (a_src[i] != 1 && a_fill[i] == 1) r = 1;
    return r;
  endfunction

  // queue choice for an attach, per R2 and R3
  function automatic int goes_def(int k);
    if (k == 6) return 1;
    if (a_n > 0 && a_kind[0] == 6) return 1;
    if (d_n > 0) return 1;
    if (m_svc == 1 && m_pinv == 1) return 1;
    if (m_svc == 1 && f_wr(k) == 1 && (m_pmod == 0 || m_pdwn == 1 || m_fwd == 1)) return 1;
    return 0;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic cmp_state();
    chk("R1", "busy", int'(busy), m_busy);
    chk("R6", "in_service", int'(in_service), m_svc);
    chk("R6", "pend_mod", int'(pend_mod), m_pmod);
    chk("R3", "post_inval", int'(post_inval), m_pinv);
    chk("R3", "post_down", int'(post_down), m_pdwn);
    chk("R11", "act_count", int'(act_count), a_n);
    chk("R2", "def_count", int'(def_count), d_n);
    chk("R5", "need_wr", int'(need_wr), sum_wr());
    chk("R5", "has_upgrade", int'(has_upgrade), sum_upg());
    chk("R5", "fill_alloc", int'(fill_alloc), sum_fill());
    if (a_n > 0) begin
      chk("R11", "act_head_kind", int'(act_head_kind), a_kind[0]);
      chk("R11", "act_head_order", int'(act_head_order), a_ord[0]);
      chk("R1", "act_head_src", int'(act_head_src), a_src[0]);
      chk("R7", "act_head_pend", int'(act_head_pend), a_pend[0]);
    end
    if (d_n > 0) begin
      chk("R4", "def_head_kind", int'(def_head_kind), d_kind[0]);
      chk("R2", "def_head_order", int'(def_head_order), d_ord[0]);
    end
  endtask

  task automatic step(input int op, input int k, input int s, input int fl, input int ord,
                      input int spm, input int sinv, input int sdwn, input int afwd);
    int e_err, e_stall, dst;
    @(negedge clk);
    cmp_state();
    op_valid = 1'b1; op_code = 3'(op); tgt_kind = 4'(k); tgt_src = 2'(s);
    tgt_fill = 1'(fl); tgt_order = 8'(ord); svc_pend_mod = 1'(spm);
    snp_inv_set = 1'(sinv); snp_dwn_set = 1'(sdwn); alloc_fwd = 1'(afwd);
    e_err = 0; e_stall = 0; dst = 0;
    case (op)
      0: e_err = m_busy;
      1: begin
        if (m_busy == 0 || k == 5) e_err = 1;
        else begin
          dst = goes_def(k);
          e_stall = (dst == 1) ? (d_n == DEPTH) : (a_n == DEPTH);
        end
      end
      2: e_err = (m_busy == 0 || m_svc == 1);
      3: e_err = (a_n == 0);
      4: e_err = (m_busy == 0 || a_n != 0);
      default: ;
    endcase
    #1;
    chk("R9", "err", int'(err), e_err);
    chk("R8", "stall", int'(stall), e_stall);
    @(posedge clk);
    // model update
    if (e_err == 0 && e_stall == 0) begin
      case (op)
        0: begin
          m_busy = 1; m_svc = 0; m_pmod = 0; m_pinv = 0; m_pdwn = 0; m_fwd = afwd;
          a_n = 1; a_kind[0] = k; a_src[0] = (k == 5) ? 2 : 0;
          a_fill[0] = fl; a_pend[0] = 1; a_ord[0] = ord;
        end
        1: begin
          if (dst == 1) begin
            d_kind[d_n] = (m_svc == 1 && m_pinv == 1) ? f_failk(k) : k;
            d_ord[d_n] = ord; d_n++;
          end else begin
            a_kind[a_n] = k; a_src[a_n] = s; a_fill[a_n] = fl;
            a_pend[a_n] = (m_svc == 0); a_ord[a_n] = ord; a_n++;
          end
        end
        2: begin
          m_pmod = (sum_wr() == 1 || spm == 1); m_svc = 1; m_pinv = 0; m_pdwn = 0;
        end
        3: begin
          for (int i = 0; i < DEPTH - 1; i++) begin
            a_kind[i] = a_kind[i+1]; a_src[i] = a_src[i+1]; a_fill[i] = a_fill[i+1];
            a_pend[i] = a_pend[i+1]; a_ord[i] = a_ord[i+1];
          end
          a_n--;
        end
        4: begin
          m_busy = 0; m_svc = 0; m_pmod = 0; m_pinv = 0; m_pdwn = 0; m_fwd = 0; d_n = 0;
        end
        default: ;
      endcase
    end
    if (!(op == 2 && e_err == 0) && !(op == 4 && e_err == 0) && !(op == 0 && e_err == 0)
        && m_busy == 1 && m_svc == 1) begin
      if (sinv == 1) m_pinv = 1;
      if (sdwn == 1) m_pdwn = 1;
    end
  endtask

  task automatic drain_and_release();
    while (a_n > 0) step(3, 0, 0, 0, 0, 0, 0, 0, 0);
    step(4, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1bad5eed));
    rst_n = 1'b0; op_valid = 1'b0; op_code = '0; tgt_kind = '0; tgt_src = '0;
    tgt_fill = 1'b0; tgt_order = '0; svc_pend_mod = 1'b0; snp_inv_set = 1'b0;
    snp_dwn_set = 1'b0; alloc_fwd = 1'b0;
    m_busy = 0; m_svc = 0; m_pmod = 0; m_pinv = 0; m_pdwn = 0; m_fwd = 0; a_n = 0; d_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // reset state
    cmp_state();

    // R1: prefetch claim takes prefetcher source; R7 pending before issue
    step(0, 5, 0, 1, 10, 0, 0, 0, 0);
    step(1, 0, 0, 0, 11, 0, 0, 0, 0);
    // R2: maintenance defers, then deferred queue pulls the next one
    step(1, 6, 0, 0, 12, 0, 0, 0, 0);
    step(1, 0, 0, 0, 13, 0, 0, 0, 0);
    // R9: prefetch attach and claim while busy
    step(1, 5, 0, 0, 14, 0, 0, 0, 0);
    step(0, 0, 0, 0, 15, 0, 0, 0, 0);
    // R10: release with active requesters refused
    step(4, 0, 0, 0, 0, 0, 0, 0, 0);
    drain_and_release();

    // R3: issued without modified pending defers a writable requester
    step(0, 0, 0, 0, 20, 0, 0, 0, 0);
    step(2, 0, 0, 0, 0, 0, 0, 0, 0);
    step(1, 1, 0, 0, 21, 0, 0, 0, 0);
    drain_and_release();

    // R5 snoop excluded; R6 modified pending; R7 no pend after issue; R4 rewrite
    step(0, 1, 0, 0, 30, 0, 0, 0, 0);
    step(1, 2, 1, 1, 31, 0, 0, 0, 0);
    step(2, 0, 0, 0, 0, 0, 0, 0, 0);
    step(1, 2, 0, 0, 32, 0, 0, 0, 0);
    step(3, 0, 0, 0, 0, 0, 0, 0, 0);
    step(3, 0, 0, 0, 0, 0, 1, 0, 0);
    step(1, 2, 0, 0, 33, 0, 0, 0, 0);
    step(1, 4, 0, 0, 34, 0, 0, 0, 0);
    drain_and_release();

    // R8: fill the active queue and overflow it; forward bit path
    step(0, 0, 0, 0, 40, 0, 0, 0, 1);
    for (int i = 0; i < 4; i++) step(1, 0, 0, 1, 41 + i, 0, 0, 0, 0);
    step(2, 0, 0, 0, 0, 1, 0, 0, 0);
    step(1, 1, 0, 0, 50, 0, 0, 0, 0);
    drain_and_release();

    // constrained random mix
    for (int n = 0; n < 3000; n++) begin
      int r, op, k;
      r = $urandom % 16;
      if (r < 2) op = 0;
      else if (r < 9) op = 1;
      else if (r < 11) op = 2;
      else if (r < 14) op = 3;
      else if (r < 15) op = 4;
      else op = 5 + ($urandom % 3);
      k = $urandom % 10;
      step(op, k, $urandom % 3, $urandom % 2, $urandom % 256, $urandom % 2,
           ($urandom % 8) == 0, ($urandom % 8) == 0, ($urandom % 4) == 0);
    end
    @(negedge clk);
    op_valid = 1'b0;
    cmp_state();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule